// File: doc/BRIEF.md
# Parallel Slave Host Port

This block lets an external host processor trade bytes with an on-chip microcontroller over an asynchronous 8-bit parallel bus. On the host side there are an active-low chip select, active-low read and write strobes, a single address line and separate input and output data buses. The host strobes and the address line are resynchronised into the system clock. Host write data is captured a programmable number of clocks after the write strobe is seen. With the address line high, a host write goes into a small byte FIFO and a host read takes the one outbound byte. With the address line low, the host reads a short status byte instead.

The microcontroller side is a plain register port with three registers: control, status and data. Writing the data register loads the outbound byte and raises a ready flag. Reading the data register pops the oldest host byte. Two interrupt requests come out of the block. One reports busy, meaning new host data has arrived. The other is a sticky error that covers both a host write into a full FIFO and a host read with no byte ready. Each request is masked by its own enable in the control register.

Top module: `hsi_host_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x80, both interrupt outputs are low and `host_dout_oe` is low.
- R2: While control bit 7 (enable) is clear, host cycles have no effect: no byte enters the FIFO, the status flags do not change and `host_dout_oe` stays low.
- R3: Control bits 4:2 hold a wait value N (code 0 behaves as 1). A host write captures `host_din` on the rising clock edge that comes N+2 edges after the first edge at which chip select and write strobe are both low.
- R4: A host write with `host_a0`=1 appends the captured byte to a 4-entry FIFO. A register-port read of address 2 returns the oldest byte and removes it, in first-in first-out order.
- R5: Status bit 7 is 1 exactly when the FIFO holds no bytes.
- R6: Status bit 6 (busy) is set when a host data write lands in an empty FIFO. A register-port write to address 1 loads bit 6 from write-data bit 6.
- R7: Status bit 5 (error) is set by a host data write while the FIFO is full, and that byte is discarded. It is also set by a host data read (`host_a0`=1) while the ready flag is clear. It stays set until a register-port write to address 1 with write-data bit 5 at 0.
- R8: A register-port write to address 2 loads the outbound byte and sets status bit 4 (ready). A host data read drives that byte on `host_dout`. The ready flag clears once the host has ended that read by raising its read strobe.
- R9: A host read with `host_a0`=0 returns a status byte with ready in bit 7, FIFO-empty in bit 6 and 0 in bits 5:0. A host write with `host_a0`=0 leaves the FIFO unchanged.
- R10: `irq_busy` equals the busy flag ANDed with control bit 6. `irq_err` equals the error flag ANDed with control bit 5.
- R11: Control bits 1:0 and status bits 3:0 always read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_a0 | input | 1 | Host address line: 1 selects data, 0 selects status |
| host_din | input | 8 | Data driven by the host during writes |
| host_dout | output | 8 | Data returned to the host during reads |
| host_dout_oe | output | 1 | High while the host read bus should be driven |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe, one clock |
| reg_rd | input | 1 | Register read strobe, one clock (pops FIFO at address 2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_busy | output | 1 | Masked busy interrupt request |
| irq_err | output | 1 | Masked overrun/underrun interrupt request |

## Verification
The bench builds the block with its default parameters: a four-entry FIFO and two synchroniser stages. With a depth of four, the full condition and the discard of a fifth byte come after only a handful of host writes, so the bench reaches them often. Every wait code from 0 to 7 is programmed. The host data is valid for exactly one clock, at the predicted capture edge, so a capture one clock early or late returns a wrong byte.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       en;
        logic       busy_ie;
        logic       err_ie;
        logic [2:0] ws;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic err;
        logic ready;
    } flags_t;

    function automatic byte_t ctrl_byte(ctrl_t c);
        return {c, 2'b00};
    endfunction

    function automatic byte_t stat_byte(logic empty, flags_t f);
        return {empty, f.busy, f.err, f.ready, 4'b0000};
    endfunction

    function automatic byte_t host_stat_byte(logic ready, logic empty);
        return {ready, empty, 6'b000000};
    endfunction

    function automatic logic [2:0] eff_wait(logic [2:0] ws);
        return (ws == 3'd0) ? 3'd1 : ws;
    endfunction

endpackage

// File: rtl/hsi_sync.sv
module hsi_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsi_byte_fifo.sv
module hsi_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + LW'(push) - LW'(pop);
        end
    end

    assign rdata = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == LW'(DEPTH));
    assign level = cnt;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LW'(DEPTH));
endmodule

// File: rtl/hsi_host_port.sv
module hsi_host_port
    import hsi_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_cs_n,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic       host_a0,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       host_dout_oe,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_busy,
    output logic       irq_err
);
    localparam int LW = $clog2(FIFO_DEPTH+1);

    // synchronised host controls: {a0, wr_n, rd_n, cs_n}
    logic [3:0] hs;
    hsi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) sync_i (
        .clk(clk), .rst(rst),
        .d({host_a0, host_wr_n, host_rd_n, host_cs_n}),
        .q(hs)
    );

    ctrl_t  ctrl_q;
    flags_t flags_q, flags_d;
    byte_t  tx_q;

    logic en, a0_s, wr_act, rd_act, wr_prev, rd_prev;
    logic wr_start, rd_start, rd_end;
    logic [2:0] wait_cnt;
    logic wr_a0_q, rd_a0_q;
    logic sample_evt, push, pop, ovr_evt, udr_evt, rd_done;
    logic f_empty, f_full;
    byte_t f_rdata;
    logic [LW-1:0] f_level;
    logic ctrl_we, sta_we, dat_we;
    reg_addr_e ra;

    assign en     = ctrl_q.en;
    assign a0_s   = hs[3];
    assign wr_act = en && !hs[0] && !hs[2];
    assign rd_act = en && !hs[0] && !hs[1];

    assign wr_start = wr_act && !wr_prev;
    assign rd_start = rd_act && !rd_prev;
    assign rd_end   = en && rd_prev && !rd_act;

    // strobe edge tracking and write sample timer
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev  <= 1'b0;
            rd_prev  <= 1'b0;
            wait_cnt <= '0;
            wr_a0_q  <= 1'b0;
            rd_a0_q  <= 1'b0;
        end else begin
            wr_prev <= wr_act;
            rd_prev <= rd_act;
            if (rd_start) rd_a0_q <= a0_s;
            if (!en) begin
                wait_cnt <= '0;
            end else if (wr_start) begin
                wait_cnt <= eff_wait(ctrl_q.ws);
                wr_a0_q  <= a0_s;
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end

    assign sample_evt = en && (wait_cnt == 3'd1);
    assign push       = sample_evt && wr_a0_q && !f_full;
    assign ovr_evt    = sample_evt && wr_a0_q && f_full;
    assign udr_evt    = rd_start && a0_s && !flags_q.ready;
    assign rd_done    = rd_end && rd_a0_q;

    assign ra      = reg_addr_e'(reg_addr);
    assign ctrl_we = reg_wr && (ra == RA_CTRL);
    assign sta_we  = reg_wr && (ra == RA_STAT);
    assign dat_we  = reg_wr && (ra == RA_DATA);
    assign pop     = reg_rd && (ra == RA_DATA) && !f_empty;

    hsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) fifo_i (
        .clk(clk), .rst(rst),
        .push(push), .pop(pop), .wdata(host_din),
        .rdata(f_rdata), .empty(f_empty), .full(f_full), .level(f_level)
    );

    // flag update: hardware sets take priority over a software write
    always_comb begin
        flags_d = flags_q;
        if (sta_we) begin
            flags_d.busy = reg_wdata[6];
            flags_d.err  = reg_wdata[5];
        end
        if (rd_done)              flags_d.ready = 1'b0;
        if (dat_we)               flags_d.ready = 1'b1;
        if (push && f_empty)      flags_d.busy  = 1'b1;
        if (ovr_evt || udr_evt)   flags_d.err   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            tx_q    <= '0;
        end else begin
            flags_q <= flags_d;
            if (ctrl_we) ctrl_q <= ctrl_t'(reg_wdata[7:2]);
            if (dat_we)  tx_q   <= reg_wdata;
        end
    end

    always_comb begin
        case (ra)
            RA_CTRL: reg_rdata = ctrl_byte(ctrl_q);
            RA_STAT: reg_rdata = stat_byte(f_empty, flags_q);
            RA_DATA: reg_rdata = f_empty ? 8'h00 : f_rdata;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign host_dout    = host_a0 ? tx_q : host_stat_byte(flags_q.ready, f_empty);
    assign host_dout_oe = en && !host_cs_n && !host_rd_n;
    assign irq_busy     = flags_q.busy && ctrl_q.busy_ie;
    assign irq_err      = flags_q.err && ctrl_q.err_ie;

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.err) |-> $past(ovr_evt || udr_evt || (sta_we && reg_wdata[5])));
    assert_busy_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.busy) |-> $past((push && f_empty) || (sta_we && reg_wdata[6])));
    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.ready) |-> $past(rd_end && rd_a0_q));
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !pop) |=> $stable(f_level));
    assert_status_side_R9: assert property (@(posedge clk) disable iff (rst)
        (sample_evt && !wr_a0_q && !pop) |=> $stable(f_level));
endmodule

// File: tb/hsi_host_port_tb_top.sv
module hsi_host_port_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic host_dout_oe;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic irq_busy, irq_err;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [7:0] q[$];
    logic m_busy = 0, m_err = 0, m_ready = 0;
    logic [7:0] m_tx = 0, m_ctl = 0;

    always #2 clk = ~clk;

    hsi_host_port dut_i (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_a0(host_a0), .host_din(host_din),
        .host_dout(host_dout), .host_dout_oe(host_dout_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_busy(irq_busy), .irq_err(irq_err)
    );

    function automatic logic [7:0] exp_status();
        return {q.size() == 0, m_busy, m_err, m_ready, 4'b0000};
    endfunction

    function automatic int wait_of(logic [7:0] ctl);
        return (ctl[4:2] == 3'd0) ? 1 : int'(ctl[4:2]);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic mcu_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) m_ctl = {d[7:2], 2'b00};
        if (a == 2'd1) begin m_busy = d[6]; m_err = d[5]; end
        if (a == 2'd2) begin m_tx = d; m_ready = 1'b1; end
    endtask

    task automatic mcu_check(string tag, logic [1:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic mcu_pop(string tag);
        logic [7:0] e;
        e = q.pop_front();
        @(negedge clk);
        reg_addr = 2'd2; reg_rd = 1'b1;
        #1 chk(tag, reg_rdata, e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // data valid only on the predicted capture edge
    task automatic host_write(logic a0, logic [7:0] d, int n, logic model);
        @(negedge clk);
        host_a0 = a0; host_cs_n = 1'b0; host_wr_n = 1'b0; host_din = ~d;
        repeat (n + 2) @(negedge clk);
        host_din = d;
        @(negedge clk);
        host_din = ~d; host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (model && a0) begin
            if (q.size() == 4) m_err = 1'b1;
            else begin
                if (q.size() == 0) m_busy = 1'b1;
                q.push_back(d);
            end
        end
    endtask

    task automatic host_read(string tag, logic a0, logic [7:0] exp, logic exp_oe);
        @(negedge clk);
        host_a0 = a0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1;
        chk({tag, " oe"}, {7'b0, host_dout_oe}, {7'b0, exp_oe});
        if (exp_oe) chk(tag, host_dout, exp);
        repeat (3) @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (exp_oe && a0) begin
            if (!m_ready) m_err = 1'b1;
            m_ready = 1'b0;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        mcu_check("R1 ctrl", 2'd0, 8'h00);
        mcu_check("R1 status", 2'd1, 8'h80);
        chk("R1 irq", {6'b0, irq_busy, irq_err}, 8'h00);
        chk("R1 oe", {7'b0, host_dout_oe}, 8'h00);

        // R2 disabled block ignores the host
        host_write(1'b1, 8'h55, 1, 1'b0);
        mcu_check("R2 status after write", 2'd1, 8'h80);
        host_read("R2 read", 1'b1, 8'h00, 1'b0);
        mcu_check("R2 status after read", 2'd1, 8'h80);

        // R11 reserved bits and unused address
        mcu_write(2'd0, 8'h8F);
        mcu_check("R11 ctrl reserved", 2'd0, 8'h8C);
        mcu_check("R11 addr3", 2'd3, 8'h00);

        // R3 exact capture edge with N=3, R6 busy set, R10 masked
        host_write(1'b1, 8'hA5, 3, 1'b1);
        mcu_check("R6 busy set", 2'd1, exp_status());
        chk("R10 busy masked", {7'b0, irq_busy}, 8'h00);
        mcu_write(2'd0, 8'hCC);
        chk("R10 busy irq", {7'b0, irq_busy}, 8'h01);

        // R9 status-side write leaves FIFO unchanged
        host_write(1'b0, 8'h77, 3, 1'b1);
        mcu_check("R9 write ignored", 2'd1, exp_status());

        // R4/R7 fill and overrun
        host_write(1'b1, 8'h11, 3, 1'b1);
        host_write(1'b1, 8'h22, 3, 1'b1);
        host_write(1'b1, 8'h33, 3, 1'b1);
        chk("R7 no err yet", {7'b0, irq_err}, 8'h00);
        mcu_write(2'd0, 8'hEC);
        host_write(1'b1, 8'h44, 3, 1'b1);
        mcu_check("R7 overrun flag", 2'd1, exp_status());
        chk("R7 err irq", {7'b0, irq_err}, 8'h01);
        for (int i = 0; i < 4; i++) mcu_pop("R3 R4 fifo order");
        mcu_check("R5 empty again", 2'd1, exp_status());

        // R6/R7 software acknowledge and set
        mcu_write(2'd1, 8'h00);
        mcu_check("R7 ack", 2'd1, 8'h80);
        chk("R10 irqs low", {6'b0, irq_busy, irq_err}, 8'h00);
        mcu_write(2'd1, 8'h40);
        mcu_check("R6 sw set", 2'd1, 8'hC0);
        mcu_write(2'd1, 8'h00);

        // R7 underrun, R9 status read, R8 outbound path
        host_read("R9 status read", 1'b0, 8'h40, 1'b1);
        mcu_check("R9 no err from status read", 2'd1, exp_status());
        host_read("R7 underrun read", 1'b1, 8'h00, 1'b1);
        mcu_check("R7 underrun flag", 2'd1, exp_status());
        mcu_write(2'd1, 8'h00);
        mcu_write(2'd2, 8'h3C);
        mcu_check("R8 ready set", 2'd1, exp_status());
        host_read("R9 status ready", 1'b0, 8'hC0, 1'b1);
        host_read("R8 data read", 1'b1, 8'h3C, 1'b1);
        mcu_check("R8 ready cleared", 2'd1, exp_status());

        // R3 wait code 0 behaves as 1
        mcu_write(2'd0, 8'h80);
        host_write(1'b1, 8'h9E, wait_of(m_ctl), 1'b1);
        mcu_pop("R3 wait code zero");
        mcu_write(2'd1, 8'h00);

        // random traffic across all wait codes
        for (int i = 0; i < 60; i++) begin
            logic [7:0] b;
            if (i % 6 == 0) mcu_write(2'd0, {3'b111, 3'($urandom_range(0, 7)), 2'b00});
            b = 8'($urandom());
            if ($urandom_range(0, 2) != 0 || q.size() == 0)
                host_write(1'b1, b, wait_of(m_ctl), 1'b1);
            else
                mcu_pop("R3 R4 random pop");
            mcu_check("R5 R6 R7 random status", 2'd1, exp_status());
        end
        while (q.size() != 0) mcu_pop("R4 drain");
        mcu_check("R5 final", 2'd1, exp_status());

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule